// File: doc/BRIEF.md
# Serial-In Shift Register with Parallel Output Latch

This block collects a serial bit stream in a chain of flip-flops clocked by a shift clock, and copies the whole chain into a parallel holding register on the rising edge of a second, independent storage clock. The holding register drives the parallel output bus. An active-low enable either lets that bus drive or releases it to high impedance. The last stage of the chain is brought out on its own pin, so several units can be chained into a longer register.

An active-low clear empties the shift chain at once, with no clock needed. It leaves the holding register alone. In a typical use, a controller shifts a word in while the outputs keep showing the previous word, then pulses the storage clock to update every output at the same moment. When both clocks come from one signal, the holding register trails the chain by one pulse.

Top module: `latched_shifter`

## Requirements
- R1: While `clr_n` is low, every shift stage reads 0 and `casc_out` is 0, with no clock edge needed.
- R2: On each rising edge of `sh_clk` with `clr_n` high, stage 1 takes `ser_in` and each stage k>1 takes the old value of stage k-1.
- R3: Rising edges of `sh_clk` while `clr_n` is low leave the chain all zero.
- R4: On each rising edge of `st_clk`, the holding register takes the whole chain. Between storage edges, shift edges do not change the parallel outputs.
- R5: The clear does not touch the holding register. A storage edge after a clear loads all zeros.
- R6: With `oe_n` high, all bits of `par_out` are high impedance. With `oe_n` low, they drive the holding register.
- R7: `casc_out` always equals the last stage, whatever `oe_n` and the holding register hold.
- R8: `par_out[0]` is stage 1 and `par_out[WIDTH-1]` is the last stage. After WIDTH shifts, the first bit shifted in appears on `par_out[WIDTH-1]` and on `casc_out`.
- R9: With `sh_clk` and `st_clk` tied together, the parallel outputs show the chain as it stood one pulse earlier.
- R10: When two units share their clocks and the second unit's `ser_in` is the first unit's `casc_out`, 2*WIDTH shifts place the first bit at the second unit's last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sh_clk | input | 1 | Shift clock, rising edge |
| st_clk | input | 1 | Storage clock, rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| ser_in | input | 1 | Serial data into stage 1 |
| oe_n | input | 1 | Output enable for the parallel bus, active low |
| par_out | output | WIDTH | Parallel outputs from the holding register, or high impedance |
| casc_out | output | 1 | Last shift stage, used to chain units |

## Verification
The walking-one and walking-zero words show whether any bit lands in the wrong position, so they catch a reversed bit order. The alternating and irregular words show whether the shift takes neighbour values or repeats a stage. Words that are shifted in without a storage pulse show whether the outputs leak before they are latched. Pulses on tied clocks, and a 16-bit stream through two chained units, check the one-pulse lag and the path through the cascade pin. A pull-up on the bench side of the bus shows when the outputs float, and clears applied while the outputs are disabled show that the holding register keeps its value.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int DEF_WIDTH = 8;
endpackage

// File: rtl/lsr_shift_chain.sv
module lsr_shift_chain #(
  parameter int WIDTH = lsr_pkg::DEF_WIDTH
) (
  input  logic             sh_clk,
  input  logic             st_clk,
  input  logic             clr_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages
);
  localparam int TOP = WIDTH - 1;

  always_ff @(posedge sh_clk or negedge clr_n) begin
    if (!clr_n) stages <= '0;
    else        stages <= {stages[TOP-1:0], ser_in};
  end

  // R2: neighbour transfer along the chain
  assert_shift_R2: assert property (@(posedge sh_clk) disable iff (!clr_n)
    1'b1 |=> stages[TOP:1] == $past(stages[TOP-1:0]));

  // R2: stage 1 captures the serial input
  assert_entry_R2: assert property (@(posedge sh_clk) disable iff (!clr_n)
    1'b1 |=> stages[0] == $past(ser_in));

  // R1: a held clear is seen as an empty chain by the storage domain
  assert_clear_R1: assert property (@(posedge st_clk)
    !clr_n |-> stages == '0);
endmodule

// File: rtl/lsr_hold_bank.sv
module lsr_hold_bank #(
  parameter int WIDTH = lsr_pkg::DEF_WIDTH
) (
  input  logic             st_clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] hold
);
  always_ff @(posedge st_clk) begin
    hold <= din;
  end

  // R4: holding register shows the chain sampled at the previous storage edge
  assert_load_R4: assert property (@(posedge st_clk)
    1'b1 |=> hold == $past(din));
endmodule

// File: rtl/lsr_out_gate.sv
module lsr_out_gate #(
  parameter int WIDTH = lsr_pkg::DEF_WIDTH
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] hold,
  output logic [WIDTH-1:0] pads
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    assign pads[i] = oe_n ? 1'bz : hold[i];
  end
endmodule

// File: rtl/latched_shifter.sv
module latched_shifter #(
  parameter int WIDTH = lsr_pkg::DEF_WIDTH
) (
  input  logic             sh_clk,
  input  logic             st_clk,
  input  logic             clr_n,
  input  logic             ser_in,
  input  logic             oe_n,
  output logic [WIDTH-1:0] par_out,
  output logic             casc_out
);
  logic [WIDTH-1:0] chain;
  logic [WIDTH-1:0] held;

  lsr_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .sh_clk (sh_clk),
    .st_clk (st_clk),
    .clr_n  (clr_n),
    .ser_in (ser_in),
    .stages (chain)
  );

  lsr_hold_bank #(.WIDTH(WIDTH)) u_hold (
    .st_clk (st_clk),
    .din    (chain),
    .hold   (held)
  );

  lsr_out_gate #(.WIDTH(WIDTH)) u_gate (
    .oe_n (oe_n),
    .hold (held),
    .pads (par_out)
  );

  assign casc_out = chain[WIDTH-1];

  // R7: cascade pin follows the stage before the last one, one shift later
  assert_casc_R7: assert property (@(posedge sh_clk) disable iff (!clr_n)
    1'b1 |=> casc_out == $past(chain[WIDTH-2]));
endmodule

// File: tb/sim_latched_shifter.sv
module sim_latched_shifter;
  localparam int W = 8;
  localparam int CLK_PERIOD = 4;
  localparam int NPAT = 6;
  localparam logic [W-1:0] PATS [NPAT] = '{8'h01, 8'hFE, 8'hA5, 8'h5A, 8'h80, 8'h3C};

  logic sh_clk = 0, st_clk = 0, clr_n = 1, ser_in = 0, oe_n = 1;
  wire  [W-1:0] pw;
  wire  [W-1:0] pw1;
  wire  casc0, casc1;
  logic oe1_n = 0;

  int checks = 0, failures = 0;
  logic [W-1:0] mshift, mhold;

  for (genvar i = 0; i < W; i++) begin : g_pull
    pullup (pw[i]);
  end

  latched_shifter #(.WIDTH(W)) u0 (
    .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n), .ser_in(ser_in),
    .oe_n(oe_n), .par_out(pw), .casc_out(casc0));

  latched_shifter #(.WIDTH(W)) u1 (
    .sh_clk(sh_clk), .st_clk(st_clk), .clr_n(clr_n), .ser_in(casc0),
    .oe_n(oe1_n), .par_out(pw1), .casc_out(casc1));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sh_pulse(input logic b);
    ser_in = b;
    #1 sh_clk = 1;
    #(CLK_PERIOD/2) sh_clk = 0;
    #1;
    if (clr_n) mshift = {mshift[W-2:0], b};
  endtask

  task automatic st_pulse();
    #1 st_clk = 1;
    #(CLK_PERIOD/2) st_clk = 0;
    #1;
    mhold = mshift;
  endtask

  task automatic both_pulse(input logic b);
    ser_in = b;
    #1 begin sh_clk = 1; st_clk = 1; end
    #(CLK_PERIOD/2) begin sh_clk = 0; st_clk = 0; end
    #1;
    mhold = mshift;
    mshift = {mshift[W-2:0], b};
  endtask

  task automatic load_word(input logic [W-1:0] w);
    for (int k = W - 1; k >= 0; k--) sh_pulse(w[k]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mshift = '0; mhold = '0;
    // reset state: clear held across a shift edge
    #2 clr_n = 0;
    #1 chk("R1 clear casc without clock", {15'd0, casc0}, 16'd0);
    sh_pulse(1'b1);
    chk("R3 shift edge ignored in clear", {15'd0, casc0}, 16'd0);
    clr_n = 1;
    mshift = '0;
    st_pulse();
    chk("R6 disabled bus floats", {8'd0, pw}, 16'h00FF);
    oe_n = 0; #1;
    chk("R5 clear then load gives zeros", {8'd0, pw}, 16'd0);

    // table of words
    for (int p = 0; p < NPAT; p++) begin
      load_word(PATS[p]);
      chk("R4 outputs stable before load", {8'd0, pw}, {8'd0, mhold});
      chk("R8 casc is last stage", {15'd0, casc0}, {15'd0, PATS[p][W-1]});
      st_pulse();
      chk("R8 bit order on bus", {8'd0, pw}, {8'd0, PATS[p]});
    end

    // R7: casc independent of enable
    oe_n = 1; #1;
    chk("R7 casc with outputs off", {15'd0, casc0}, {15'd0, mshift[W-1]});
    chk("R6 bus floats again", {8'd0, pw}, 16'h00FF);
    // R5: clear while disabled keeps holding register
    clr_n = 0; #1;
    chk("R1 chain zero during clear", {15'd0, casc0}, 16'd0);
    sh_pulse(1'b1);
    clr_n = 1; mshift = '0;
    oe_n = 0; #1;
    chk("R5 holding survives clear", {8'd0, pw}, {8'd0, PATS[NPAT-1]});
    st_pulse();
    chk("R5 load after clear", {8'd0, pw}, 16'd0);

    // R9: tied clocks lag by one pulse
    for (int k = 0; k < 10; k++) begin
      both_pulse(k[0] ^ k[2]);
      chk("R9 tied clocks lag", {8'd0, pw}, {8'd0, mhold});
    end

    // R10: cascade of two units, 16 shifts
    begin
      logic [15:0] word;
      word = 16'hC3A1;
      clr_n = 0; #1; sh_pulse(1'b0); clr_n = 1; mshift = '0;
      for (int k = 15; k >= 0; k--) sh_pulse(word[k]);
      st_pulse();
      chk("R10 upper unit word", {8'd0, pw1}, {8'd0, word[15:8]});
      chk("R10 lower unit word", {8'd0, pw}, {8'd0, word[7:0]});
      chk("R10 far casc first bit", {15'd0, casc1}, {15'd0, word[15]});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule